// File: doc/BRIEF.md
# Processor exception entry sequencer

This block performs the hardware half of entering a synchronous exception. Four fault sources feed it: an access to an unmapped address, a misaligned access, an undefined opcode and a breakpoint instruction. When any of them is raised while the block is idle, the block captures the faulting instruction address, the stack pointer, the status word and the whole register file. It then runs a fixed entry sequence.

The sequence pushes two values through a single memory write port that uses a valid/ready handshake. The first push is the return address, written as a full word. The second push is the status word, written as a halfword. After the second push is accepted, the core is told to clear interrupt enable in its status word. One cycle later the core is told to lower its stack pointer by eight and to jump to the fixed vector address.

A cause code and the captured register snapshot stay readable for debug. A pending flag marks an exception that the handler has not yet acknowledged. A nested flag warns when a further fault is taken while an earlier exception is still pending.

Top module: `exc_entry_seq`

## Requirements
- R1: `cause_code` is 0 after reset. When a trigger is accepted it becomes 1 for unmapped, 2 for misaligned, 3 for illegal opcode or 4 for breakpoint. When several sources are raised in the same cycle, the highest-priority one is recorded, in the order unmapped > misaligned > illegal > breakpoint. The code holds until the next accepted trigger.
- R2: The cycle after a trigger is accepted, the write port presents a word store (`mem_wr_word`=1) of the captured PC at captured SP minus 4. Valid, address and data are held stable until `mem_wr_ready` is seen high.
- R3: Only after the first store is accepted, the port presents a halfword store (`mem_wr_word`=0) at captured SP minus 8. The data carries the captured status word in bits 15:0, with bits 31:16 zero.
- R4: `psw_wr_en` pulses for exactly the cycle in which the halfword store is accepted, never earlier. `psw_wr_val` then equals the captured status word with interrupt-enable bit 11 cleared and every other bit unchanged.
- R5: In the cycle after the halfword store is accepted, `pc_wr_en` and `sp_wr_en` pulse together for one cycle. `pc_wr_val` is 0x40000008 and `sp_wr_val` is captured SP minus 8.
- R6: `busy` is low after reset. It goes high the cycle after a trigger is accepted, stays high through the commit cycle of R5, and is low in the following cycle.
- R7: Fault inputs raised while `busy` is high are ignored. They change neither the cause code, the store sequence nor the snapshot, and they start no further sequence.
- R8: `snap_data` returns entry `snap_sel` of the register file as it stood in the cycle the trigger was accepted. Later changes to `core_regs` do not affect it until the next accepted trigger.
- R9: `exc_pending` rises on an accepted trigger. `exc_nested` rises when a trigger is accepted while `exc_pending` is already high. A `handler_done` pulse clears both flags.
- R10: After reset the write port, `psw_wr_en`, `pc_wr_en`, `sp_wr_en`, `exc_pending` and `exc_nested` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_unmapped | input | 1 | Access to an unmapped address |
| flt_misalign | input | 1 | Misaligned access |
| flt_illegal | input | 1 | Undefined opcode |
| flt_break | input | 1 | Breakpoint instruction |
| core_pc | input | 32 | Address of the faulting instruction |
| core_sp | input | 32 | Current stack pointer |
| core_psw | input | 16 | Current status word |
| core_regs | input | NREG*32 | Register file contents, entry i in bits 32*i+31:32*i |
| handler_done | input | 1 | Handler acknowledges the exception; clears pending and nested |
| mem_wr_valid | output | 1 | Store request |
| mem_wr_ready | input | 1 | Store accepted |
| mem_wr_addr | output | 32 | Store address |
| mem_wr_data | output | 32 | Store data |
| mem_wr_word | output | 1 | 1 for a 32-bit store, 0 for a 16-bit store |
| psw_wr_en | output | 1 | Status word update strobe |
| psw_wr_val | output | 16 | New status word |
| pc_wr_en | output | 1 | Program counter update strobe |
| pc_wr_val | output | 32 | New program counter |
| sp_wr_en | output | 1 | Stack pointer update strobe |
| sp_wr_val | output | 32 | New stack pointer |
| busy | output | 1 | Entry sequence in progress |
| cause_code | output | 3 | Cause of the last accepted exception |
| exc_pending | output | 1 | Exception taken and not yet acknowledged |
| exc_nested | output | 1 | Exception taken while another was pending |
| snap_sel | input | $clog2(NREG) | Snapshot entry select |
| snap_data | output | 32 | Selected snapshot entry |

## Verification
Single-source triggers show that each fault maps to its own code. Simultaneous multi-source triggers distinguish a correct priority order from a reversed or partial one. Random store-accept delays of zero to several cycles on each push separate correct handshake holding from premature advancing. They also pin the status-word strobe to the acceptance cycle of the second push rather than to its first presentation. Faults injected mid-sequence, with the register file scrambled after capture, expose any recapture or restart while busy. Back-to-back exceptions with and without an intervening acknowledge tell a correct nested flag from one that is stuck or never set.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned PSW_W    = 16;
    localparam int unsigned IE_BIT   = 11;
    localparam logic [ADDR_W-1:0] VEC_ADDR = 32'h4000_0008;
    localparam logic [ADDR_W-1:0] RET_OFS  = 32'd4;
    localparam logic [ADDR_W-1:0] PSW_OFS  = 32'd8;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PUSH_PC  = 2'd1,
        ST_PUSH_PSW = 2'd2,
        ST_VECTOR   = 2'd3
    } seq_state_t;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_UNMAPPED = 3'd1,
        CAUSE_MISALIGN = 3'd2,
        CAUSE_ILLEGAL  = 3'd3,
        CAUSE_BREAK    = 3'd4
    } cause_t;

    typedef struct packed {
        logic unmapped;
        logic misalign;
        logic illegal;
        logic brk;
    } fault_req_t;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] sp;
        logic [PSW_W-1:0]  psw;
    } entry_ctx_t;

    function automatic cause_t pick_cause(input fault_req_t r);
        cause_t c;
        if (r.unmapped)      c = CAUSE_UNMAPPED;
        else if (r.misalign) c = CAUSE_MISALIGN;
        else if (r.illegal)  c = CAUSE_ILLEGAL;
        else if (r.brk)      c = CAUSE_BREAK;
        else                 c = CAUSE_NONE;
        return c;
    endfunction

    function automatic logic [PSW_W-1:0] mask_ie(input logic [PSW_W-1:0] p);
        logic [PSW_W-1:0] m;
        m = p;
        m[IE_BIT] = 1'b0;
        return m;
    endfunction

endpackage

// File: rtl/exc_cause_pick.sv
module exc_cause_pick
    import exc_pkg::*;
(
    input  fault_req_t req,
    output cause_t     cause,
    output logic       any
);
    always_comb begin
        cause = pick_cause(req);
        any   = req.unmapped | req.misalign | req.illegal | req.brk;
    end

    // R1
    always_comb begin
        cause_src_chk: assert ((cause != CAUSE_UNMAPPED || req.unmapped) &&
                               (cause != CAUSE_MISALIGN || (req.misalign && !req.unmapped)) &&
                               (cause != CAUSE_BREAK    || (req.brk && !req.illegal)));
    end
endmodule

// File: rtl/exc_snapshot.sv
module exc_snapshot
    import exc_pkg::*;
#(
    parameter int unsigned NREG = 16,
    localparam int unsigned SEL_W = (NREG > 1) ? $clog2(NREG) : 1
)(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     capture,
    input  logic [NREG*ADDR_W-1:0]   regs_in,
    input  logic [SEL_W-1:0]         sel,
    output logic [ADDR_W-1:0]        rd_data
);
    logic [ADDR_W-1:0] bank_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)          bank_q[i] <= '0;
            else if (capture) bank_q[i] <= regs_in[i*ADDR_W +: ADDR_W];
        end

        // R8
        snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !capture |=> $stable(bank_q[i]));
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NREG; k++)
            if (SEL_W'(k) == sel) rd_data = bank_q[k];
    end
endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
    import exc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fault_any,
    input  cause_t             fault_cause,
    input  entry_ctx_t         ctx_in,
    input  logic               handler_done,
    output logic               accept,
    output logic               mem_wr_valid,
    input  logic               mem_wr_ready,
    output logic [ADDR_W-1:0]  mem_wr_addr,
    output logic [ADDR_W-1:0]  mem_wr_data,
    output logic               mem_wr_word,
    output logic               psw_wr_en,
    output logic [PSW_W-1:0]   psw_wr_val,
    output logic               pc_wr_en,
    output logic [ADDR_W-1:0]  pc_wr_val,
    output logic               sp_wr_en,
    output logic [ADDR_W-1:0]  sp_wr_val,
    output logic               busy,
    output cause_t             cause_code,
    output logic               pending,
    output logic               nested
);
    seq_state_t state_q, state_d;
    entry_ctx_t ctx_q;
    logic [ADDR_W-1:0] sp_low;

    assign accept = (state_q == ST_IDLE) && fault_any;
    assign sp_low = ctx_q.sp - PSW_OFS;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept)       state_d = ST_PUSH_PC;
            ST_PUSH_PC:  if (mem_wr_ready) state_d = ST_PUSH_PSW;
            ST_PUSH_PSW: if (mem_wr_ready) state_d = ST_VECTOR;
            ST_VECTOR:                     state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            ctx_q      <= '0;
            cause_code <= CAUSE_NONE;
            pending    <= 1'b0;
            nested     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                ctx_q      <= ctx_in;
                cause_code <= fault_cause;
                pending    <= 1'b1;
                if (pending && !handler_done) nested <= 1'b1;
                else if (handler_done)        nested <= 1'b0;
            end else if (handler_done) begin
                pending <= 1'b0;
                nested  <= 1'b0;
            end
        end
    end

    always_comb begin
        mem_wr_valid = 1'b0;
        mem_wr_addr  = '0;
        mem_wr_data  = '0;
        mem_wr_word  = 1'b0;
        psw_wr_en    = 1'b0;
        psw_wr_val   = mask_ie(ctx_q.psw);
        pc_wr_en     = 1'b0;
        pc_wr_val    = VEC_ADDR;
        sp_wr_en     = 1'b0;
        sp_wr_val    = sp_low;
        busy         = (state_q != ST_IDLE);
        unique case (state_q)
            ST_PUSH_PC: begin
                mem_wr_valid = 1'b1;
                mem_wr_addr  = ctx_q.sp - RET_OFS;
                mem_wr_data  = ctx_q.pc;
                mem_wr_word  = 1'b1;
            end
            ST_PUSH_PSW: begin
                mem_wr_valid = 1'b1;
                mem_wr_addr  = sp_low;
                mem_wr_data  = {{(ADDR_W-PSW_W){1'b0}}, ctx_q.psw};
                psw_wr_en    = mem_wr_ready;
            end
            ST_VECTOR: begin
                pc_wr_en = 1'b1;
                sp_wr_en = 1'b1;
            end
            default: ;
        endcase
    end

    // R2
    store_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr) &&
                                            $stable(mem_wr_data) && $stable(mem_wr_word)));
    // R3
    half_after_word_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_word && $past(mem_wr_word)) |-> $past(mem_wr_valid && mem_wr_ready));
    // R5
    commit_after_psw_chk: assert property (@(posedge clk) disable iff (rst)
        psw_wr_en |=> (pc_wr_en && sp_wr_en && !mem_wr_valid));
    // R5
    commit_single_chk: assert property (@(posedge clk) disable iff (rst)
        pc_wr_en |=> !pc_wr_en && !busy);
    // R6
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);
    // R7
    cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cause_code));
    // R9
    nested_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nested) |-> $past(pending));
    // R10
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pc_wr_en, mem_wr_valid}));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int unsigned NREG = 16,
    localparam int unsigned SEL_W = (NREG > 1) ? $clog2(NREG) : 1
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flt_unmapped,
    input  logic                    flt_misalign,
    input  logic                    flt_illegal,
    input  logic                    flt_break,
    input  logic [31:0]             core_pc,
    input  logic [31:0]             core_sp,
    input  logic [15:0]             core_psw,
    input  logic [NREG*32-1:0]      core_regs,
    input  logic                    handler_done,
    output logic                    mem_wr_valid,
    input  logic                    mem_wr_ready,
    output logic [31:0]             mem_wr_addr,
    output logic [31:0]             mem_wr_data,
    output logic                    mem_wr_word,
    output logic                    psw_wr_en,
    output logic [15:0]             psw_wr_val,
    output logic                    pc_wr_en,
    output logic [31:0]             pc_wr_val,
    output logic                    sp_wr_en,
    output logic [31:0]             sp_wr_val,
    output logic                    busy,
    output logic [2:0]              cause_code,
    output logic                    exc_pending,
    output logic                    exc_nested,
    input  logic [SEL_W-1:0]        snap_sel,
    output logic [31:0]             snap_data
);
    fault_req_t req;
    cause_t     sel_cause;
    cause_t     cause_q;
    logic       fault_any;
    logic       accept;
    entry_ctx_t ctx;

    assign req = '{unmapped: flt_unmapped, misalign: flt_misalign,
                   illegal: flt_illegal, brk: flt_break};
    assign ctx = '{pc: core_pc, sp: core_sp, psw: core_psw};
    assign cause_code = cause_q;

    exc_cause_pick u_pick (
        .req   (req),
        .cause (sel_cause),
        .any   (fault_any)
    );

    exc_seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .fault_any    (fault_any),
        .fault_cause  (sel_cause),
        .ctx_in       (ctx),
        .handler_done (handler_done),
        .accept       (accept),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_ready (mem_wr_ready),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .mem_wr_word  (mem_wr_word),
        .psw_wr_en    (psw_wr_en),
        .psw_wr_val   (psw_wr_val),
        .pc_wr_en     (pc_wr_en),
        .pc_wr_val    (pc_wr_val),
        .sp_wr_en     (sp_wr_en),
        .sp_wr_val    (sp_wr_val),
        .busy         (busy),
        .cause_code   (cause_q),
        .pending      (exc_pending),
        .nested       (exc_nested)
    );

    exc_snapshot #(.NREG(NREG)) u_snap (
        .clk     (clk),
        .rst     (rst),
        .capture (accept),
        .regs_in (core_regs),
        .sel     (snap_sel),
        .rd_data (snap_data)
    );
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 16;
    localparam int SEL_W = $clog2(NREG);

    logic clk = 1'b0;
    logic rst;
    logic flt_unmapped, flt_misalign, flt_illegal, flt_break;
    logic [31:0] core_pc, core_sp;
    logic [15:0] core_psw;
    logic [NREG*32-1:0] core_regs;
    logic handler_done;
    logic mem_wr_valid, mem_wr_ready, mem_wr_word;
    logic [31:0] mem_wr_addr, mem_wr_data;
    logic psw_wr_en, pc_wr_en, sp_wr_en, busy;
    logic [15:0] psw_wr_val;
    logic [31:0] pc_wr_val, sp_wr_val, snap_data;
    logic [2:0] cause_code;
    logic exc_pending, exc_nested;
    logic [SEL_W-1:0] snap_sel;

    int checks = 0;
    int failures = 0;
    bit m_pending = 0;
    bit m_nested = 0;
    logic [31:0] exp_regs [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_seq #(.NREG(NREG)) u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_cause(input logic [3:0] m);
        if (m[0]) return 3'd1;
        if (m[1]) return 3'd2;
        if (m[2]) return 3'd3;
        if (m[3]) return 3'd4;
        return 3'd0;
    endfunction

    task automatic set_faults(input logic [3:0] m);
        flt_unmapped = m[0]; flt_misalign = m[1]; flt_illegal = m[2]; flt_break = m[3];
    endtask

    task automatic scramble_regs();
        for (int i = 0; i < NREG; i++) core_regs[i*32 +: 32] = $urandom;
    endtask

    // One complete entry; d1/d2 are ready delays; inject raises faults while busy.
    task automatic run_exc(input logic [3:0] m, input logic [31:0] pc, input logic [31:0] sp,
                           input logic [15:0] psw, input int d1, input int d2, input bit inject);
        logic [2:0] ec;
        ec = exp_cause(m);
        for (int i = 0; i < NREG; i++) begin
            exp_regs[i] = $urandom;
            core_regs[i*32 +: 32] = exp_regs[i];
        end
        core_pc = pc; core_sp = sp; core_psw = psw;
        set_faults(m);
        @(posedge clk); #1;
        set_faults(4'b0);
        scramble_regs();
        core_pc = ~pc; core_sp = ~sp; core_psw = ~psw;
        m_nested = m_pending ? 1'b1 : m_nested;
        m_pending = 1'b1;
        chk(busy === 1'b1, "R6 busy after accept", {31'b0, busy}, 32'd1);
        chk(cause_code === ec, "R1 cause", {29'b0, cause_code}, {29'b0, ec});
        chk(exc_nested === m_nested, "R9 nested", {31'b0, exc_nested}, {31'b0, m_nested});
        chk(exc_pending === 1'b1, "R9 pending", {31'b0, exc_pending}, 32'd1);
        for (int c = 0; c <= d1; c++) begin
            mem_wr_ready = (c == d1);
            if (inject && c < d1) set_faults(4'b1111);
            else set_faults(4'b0);
            #1;
            chk(mem_wr_valid === 1'b1 && mem_wr_word === 1'b1, "R2 word store valid",
                {30'b0, mem_wr_valid, mem_wr_word}, 32'd3);
            chk(mem_wr_addr === sp - 32'd4, "R2 word store addr", mem_wr_addr, sp - 32'd4);
            chk(mem_wr_data === pc, "R2 word store data", mem_wr_data, pc);
            chk(psw_wr_en === 1'b0, "R4 no early psw", {31'b0, psw_wr_en}, 32'd0);
            @(posedge clk); #1;
        end
        set_faults(4'b0);
        for (int c = 0; c <= d2; c++) begin
            mem_wr_ready = (c == d2);
            #1;
            chk(mem_wr_valid === 1'b1 && mem_wr_word === 1'b0, "R3 half store valid",
                {30'b0, mem_wr_valid, mem_wr_word}, 32'd2);
            chk(mem_wr_addr === sp - 32'd8, "R3 half store addr", mem_wr_addr, sp - 32'd8);
            chk(mem_wr_data === {16'b0, psw}, "R3 half store data", mem_wr_data, {16'b0, psw});
            chk(psw_wr_en === (c == d2), "R4 psw strobe", {31'b0, psw_wr_en}, {31'b0, (c == d2)});
            if (c == d2)
                chk(psw_wr_val === (psw & 16'hF7FF), "R4 psw IE cleared",
                    {16'b0, psw_wr_val}, {16'b0, psw & 16'hF7FF});
            @(posedge clk); #1;
        end
        mem_wr_ready = 1'b0;
        #1;
        chk(pc_wr_en === 1'b1 && sp_wr_en === 1'b1 && mem_wr_valid === 1'b0, "R5 commit strobes",
            {29'b0, pc_wr_en, sp_wr_en, mem_wr_valid}, 32'd6);
        chk(pc_wr_val === 32'h4000_0008, "R5 vector", pc_wr_val, 32'h4000_0008);
        chk(sp_wr_val === sp - 32'd8, "R5 new sp", sp_wr_val, sp - 32'd8);
        chk(busy === 1'b1, "R6 busy at commit", {31'b0, busy}, 32'd1);
        @(posedge clk); #1;
        chk(busy === 1'b0 && pc_wr_en === 1'b0, "R6 R5 idle after commit",
            {30'b0, busy, pc_wr_en}, 32'd0);
        chk(cause_code === ec, "R7 cause held", {29'b0, cause_code}, {29'b0, ec});
        for (int k = 0; k < 3; k++) begin
            int idx;
            idx = (k == 0) ? 0 : (k == 1) ? NREG-1 : int'($urandom_range(0, NREG-1));
            snap_sel = SEL_W'(idx);
            #1;
            chk(snap_data === exp_regs[idx], "R8 R7 snapshot", snap_data, exp_regs[idx]);
        end
    endtask

    task automatic ack();
        handler_done = 1'b1;
        @(posedge clk); #1;
        handler_done = 1'b0;
        m_pending = 0; m_nested = 0;
        chk(exc_pending === 1'b0 && exc_nested === 1'b0, "R9 cleared by ack",
            {30'b0, exc_pending, exc_nested}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; set_faults(4'b0); handler_done = 1'b0; mem_wr_ready = 1'b0;
        core_pc = '0; core_sp = '0; core_psw = '0; core_regs = '0; snap_sel = '0;
        @(negedge clk); @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
        #1;
        chk(busy === 1'b0 && cause_code === 3'd0, "R10 R6 R1 reset", {28'b0, busy, cause_code}, 32'd0);
        chk(mem_wr_valid === 1'b0 && psw_wr_en === 1'b0 && pc_wr_en === 1'b0 && sp_wr_en === 1'b0,
            "R10 strobes idle", {28'b0, mem_wr_valid, psw_wr_en, pc_wr_en, sp_wr_en}, 32'd0);
        chk(exc_pending === 1'b0 && exc_nested === 1'b0, "R10 flags", {30'b0, exc_pending, exc_nested}, 32'd0);
        @(posedge clk); #1;

        // Directed: each source alone
        run_exc(4'b0001, 32'h0000_1000, 32'h0008_0000, 16'h0800, 0, 0, 0); ack();
        run_exc(4'b0010, 32'h0000_2002, 32'h0008_0100, 16'hFFFF, 1, 2, 0); ack();
        run_exc(4'b0100, 32'h0000_3004, 32'h0008_0200, 16'h0000, 2, 0, 0); ack();
        run_exc(4'b1000, 32'h0000_4006, 32'h0000_0004, 16'h07FF, 0, 3, 0); ack();
        // Priority
        run_exc(4'b1111, 32'h1, 32'h100, 16'h0A5A, 0, 0, 0); ack();
        run_exc(4'b1110, 32'h2, 32'h200, 16'h0A5A, 0, 0, 0); ack();
        run_exc(4'b1100, 32'h3, 32'h300, 16'h0A5A, 0, 0, 0);
        // Nested without ack, with faults injected while busy
        run_exc(4'b1000, 32'h4, 32'h400, 16'h0800, 3, 1, 1);
        ack();
        run_exc(4'b0100, 32'h5, 32'h500, 16'h0800, 1, 1, 0);
        chk(exc_nested === 1'b0, "R9 no nest after ack", {31'b0, exc_nested}, 32'd0);

        // Random
        for (int n = 0; n < 40; n++) begin
            logic [3:0] m;
            m = 4'($urandom_range(1, 15));
            run_exc(m, $urandom, $urandom, 16'($urandom), int'($urandom_range(0, 3)),
                    int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)));
            if ($urandom_range(0, 1) == 1) ack();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule